// File: doc/BRIEF.md
# Indirect Byte Register Bridge

This block lets a host with a 32-bit register port reach an 8-bit register bus that lives in a slower power domain. The host never addresses the narrow bus directly. It programs a command word with a target address, a direction and byte enables, and the bridge then runs a single-byte transaction on the narrow side.

A write is started by writing the data word once the command word holds the target address. A read is started by the command write itself when its direction bit asks for a read. While a transaction is in flight, a busy bit in the command word stays high for a fixed, parameterised number of cycles, which stands in for the domain crossing. The host polls that bit. A read returns its byte in the low bits of the data word. The bridge also carries an interrupt request from the narrow side into a sticky host flag that software clears by writing 1. An enable bit gates that flag onto the host interrupt line.

Top module: `indirect_byte_bridge`

## Requirements
- R1: After a synchronous reset, the command word, the data word, the interrupt enable and the interrupt flag all read 0, and both `ib_req` and `host_irq` are 0.
- R2: Offset 0x00 reads the constant `ID_VALUE`, and writes to it have no effect.
- R3: Writing the command word (offset 0x04) while idle stores the direction in bit 24, the byte enables in bits 23:16 and the target address in bits IB_AW-1:0. A read of the word returns those fields, with busy in bit 31 and 0 in all other bits. Bit 31 cannot be written.
- R4: Writing the data word (offset 0x08) while idle, with the stored direction 0, starts a write. From the next cycle `ib_req`=1, `ib_we`=1, `ib_addr` is the stored address and `ib_wdata` is the written bits 7:0.
- R5: Writing the command word while idle with bit 24 = 1 starts a read. From the next cycle `ib_req`=1, `ib_we`=0 and `ib_addr` is the address just written.
- R6: Busy (command bit 31, mirrored on `ib_req`) is 1 for exactly XFER_CYCLES cycles, starting the cycle after the launch.
- R7: When a read ends, the data word holds `ib_rdata` as sampled in the last busy cycle, zero-extended to 32 bits. It can be read in the first cycle in which busy is 0.
- R8: While busy is 1, writes to the command word and to the data word change neither register and start no transaction. The narrow-bus command outputs also stay stable.
- R9: Flag bit 1 (offset 0x14) becomes 1 XFER-independent SYNC_STAGES+1 clock edges after `ib_irq` is seen high, and it stays 1. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R10: Enable bit 1 (offset 0x10) is the only writable enable bit. `host_irq` equals flag bit 1 AND enable bit 1.
- R11: Writing the data word while idle with the stored direction 1 stores the value and starts no transaction.
- R12: Offset 0x0C is a plain 32-bit read/write storage word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| host_irq | output | 1 | Gated interrupt to the host |
| ib_req | output | 1 | Narrow-bus transaction active |
| ib_we | output | 1 | 1 = write, 0 = read |
| ib_addr | output | IB_AW | Narrow-bus register address |
| ib_wdata | output | 8 | Narrow-bus write byte |
| ib_rdata | input | 8 | Narrow-bus read byte |
| ib_irq | input | 1 | Interrupt request from the slow domain |

## Verification
A launch is seen on the narrow-bus outputs one edge after the host write, so the bench checks them at the falling edge that follows the write task. Busy is polled once per cycle, and the number of high samples must equal XFER_CYCLES. A read byte is compared in the first idle sample, with no extra settling cycle allowed. The interrupt flag is polled each cycle after a one-cycle request pulse and must first appear SYNC_STAGES+1 edges later. Every check samples at the falling edge, half a period away from the edge that updates the state.

// File: rtl/bridge_pkg.sv
// Shared constants for the indirect byte bridge: host offsets and field
// positions. Assumes a word-aligned 5-bit host offset.
package bridge_pkg;
    localparam int HOST_AW = 5;
    localparam int HOST_DW = 32;
    localparam int IB_DW   = 8;

    localparam logic [HOST_AW-1:0] OFS_ID    = 5'h00;
    localparam logic [HOST_AW-1:0] OFS_CMD   = 5'h04;
    localparam logic [HOST_AW-1:0] OFS_LDATA = 5'h08;
    localparam logic [HOST_AW-1:0] OFS_UDATA = 5'h0C;
    localparam logic [HOST_AW-1:0] OFS_IEN   = 5'h10;
    localparam logic [HOST_AW-1:0] OFS_IFLG  = 5'h14;

    localparam int BUSY_POS = 31;
    localparam int DIR_POS  = 24;
    localparam int BE_LSB   = 16;
    localparam int BE_W     = 8;
    localparam int IRQ_POS  = 1;
endpackage

// File: rtl/bridge_xfer_engine.sv
// Runs one narrow-bus transaction per launch and holds it for XFER_CYCLES
// cycles. Assumes launch_i is only asserted while busy_o is 0.
module bridge_xfer_engine #(
    parameter int XFER_CYCLES = 4,
    parameter int IB_AW       = 8,
    parameter int IB_DW       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             launch_we_i,
    input  logic [IB_AW-1:0] launch_addr_i,
    input  logic [IB_DW-1:0] launch_data_i,
    output logic             busy_o,
    output logic             last_o,
    output logic             we_o,
    output logic [IB_AW-1:0] addr_o,
    output logic [IB_DW-1:0] wdata_o
);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             we_q;
    logic [IB_AW-1:0] addr_q;
    logic [IB_DW-1:0] data_q;

    // Capture the command on launch and count the busy window down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (launch_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            we_q   <= launch_we_i;
            addr_q <= launch_addr_i;
            data_q <= launch_data_i;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o  = busy_q;
    assign last_o  = busy_q && (cnt_q == CNT_W'(1));
    assign we_o    = we_q;
    assign addr_o  = addr_q;
    assign wdata_o = data_q;

    // Observation counter that measures how long each busy window lasts.
    logic [CNT_W:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n) run_len_q <= '0;
        else        run_len_q <= busy_q ? run_len_q + 1'b1 : '0;
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (run_len_q == (CNT_W+1)'(XFER_CYCLES)));

    assert_cmd_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(we_q) && $stable(data_q)));
endmodule

// File: rtl/bridge_irq_unit.sv
// Brings the slow-domain interrupt through a SYNC_STAGES delay chain into a
// sticky flag that is cleared by writing 1, and gates the flag with an enable.
// Assumes the chain models the crossing latency only.
module bridge_irq_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_async_i,
    input  logic en_we_i,
    input  logic en_d_i,
    input  logic clr_i,
    output logic en_o,
    output logic flag_o,
    output logic irq_o
);
    logic [SYNC_STAGES:0] tap;
    logic                 en_q;
    logic                 flag_q;

    assign tap[0] = irq_async_i;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        // One delay stage of the modelled crossing.
        always_ff @(posedge clk) begin
            if (!rst_n) tap[g+1] <= 1'b0;
            else        tap[g+1] <= tap[g];
        end
    end

    // Enable bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_we_i) en_q <= en_d_i;
    end

    // Sticky flag: a new request takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (tap[SYNC_STAGES])   flag_q <= 1'b1;
        else if (clr_i)              flag_q <= 1'b0;
    end

    assign en_o   = en_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q && en_q;

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tap[SYNC_STAGES] |=> flag_q);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tap[SYNC_STAGES]) |=> !flag_q);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/indirect_byte_bridge.sv
// Host-facing register file of the indirect byte bridge. Decodes host writes,
// launches narrow-bus transactions, returns read bytes and exposes the
// interrupt flag. Assumes a single-cycle host write strobe and combinational
// read data. IB_AW must not exceed 16.
module indirect_byte_bridge
    import bridge_pkg::*;
#(
    parameter int          XFER_CYCLES = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          IB_AW       = 8,
    parameter logic [31:0] ID_VALUE    = 32'h1B0D_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_irq,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IB_AW-1:0]   ib_addr,
    output logic [IB_DW-1:0]   ib_wdata,
    input  logic [IB_DW-1:0]   ib_rdata,
    input  logic               ib_irq
);
    logic             busy;
    logic             last;
    logic             cmd_dir_q;
    logic [BE_W-1:0]  cmd_be_q;
    logic [IB_AW-1:0] cmd_addr_q;
    logic [31:0]      ldata_q;
    logic [31:0]      udata_q;
    logic             irq_en;
    logic             irq_flag;

    logic wr_cmd, wr_ldata, wr_udata, wr_ien, wr_iflg;
    logic launch, launch_we;
    logic [IB_AW-1:0] launch_addr;

    // Host write decode; command and data writes are dropped while busy.
    always_comb begin
        wr_cmd   = host_wr && (host_addr == OFS_CMD)   && !busy;
        wr_ldata = host_wr && (host_addr == OFS_LDATA) && !busy;
        wr_udata = host_wr && (host_addr == OFS_UDATA);
        wr_ien   = host_wr && (host_addr == OFS_IEN);
        wr_iflg  = host_wr && (host_addr == OFS_IFLG);
    end

    // Launch select: a read command or a data write with write direction.
    always_comb begin
        launch      = 1'b0;
        launch_we   = 1'b0;
        launch_addr = cmd_addr_q;
        if (wr_cmd && host_wdata[DIR_POS]) begin
            launch      = 1'b1;
            launch_addr = host_wdata[IB_AW-1:0];
        end else if (wr_ldata && !cmd_dir_q) begin
            launch    = 1'b1;
            launch_we = 1'b1;
        end
    end

    // Command word fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_dir_q  <= 1'b0;
            cmd_be_q   <= '0;
            cmd_addr_q <= '0;
        end else if (wr_cmd) begin
            cmd_dir_q  <= host_wdata[DIR_POS];
            cmd_be_q   <= host_wdata[BE_LSB +: BE_W];
            cmd_addr_q <= host_wdata[IB_AW-1:0];
        end
    end

    // Lower data word: read completion takes the byte, else a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)              ldata_q <= '0;
        else if (last && !ib_we) ldata_q <= {{(32-IB_DW){1'b0}}, ib_rdata};
        else if (wr_ldata)       ldata_q <= host_wdata;
    end

    // Upper data word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        udata_q <= '0;
        else if (wr_udata) udata_q <= host_wdata;
    end

    bridge_xfer_engine #(
        .XFER_CYCLES (XFER_CYCLES),
        .IB_AW       (IB_AW),
        .IB_DW       (IB_DW)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_i      (launch),
        .launch_we_i   (launch_we),
        .launch_addr_i (launch_addr),
        .launch_data_i (host_wdata[IB_DW-1:0]),
        .busy_o        (busy),
        .last_o        (last),
        .we_o          (ib_we),
        .addr_o        (ib_addr),
        .wdata_o       (ib_wdata)
    );

    bridge_irq_unit #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_async_i (ib_irq),
        .en_we_i     (wr_ien),
        .en_d_i      (host_wdata[IRQ_POS]),
        .clr_i       (wr_iflg && host_wdata[IRQ_POS]),
        .en_o        (irq_en),
        .flag_o      (irq_flag),
        .irq_o       (host_irq)
    );

    assign ib_req = busy;

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_ID:    host_rdata = ID_VALUE;
            OFS_CMD: begin
                host_rdata[BUSY_POS]          = busy;
                host_rdata[DIR_POS]           = cmd_dir_q;
                host_rdata[BE_LSB +: BE_W]    = cmd_be_q;
                host_rdata[IB_AW-1:0]         = cmd_addr_q;
            end
            OFS_LDATA: host_rdata = ldata_q;
            OFS_UDATA: host_rdata = udata_q;
            OFS_IEN:   host_rdata[IRQ_POS] = irq_en;
            OFS_IFLG:  host_rdata[IRQ_POS] = irq_flag;
            default:   host_rdata = '0;
        endcase
    end

    assert_write_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_LDATA && !ib_req && !cmd_dir_q)
        |=> (ib_req && ib_we && ib_wdata == $past(host_wdata[IB_DW-1:0])));

    assert_read_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_CMD && !ib_req && host_wdata[DIR_POS])
        |=> (ib_req && !ib_we && ib_addr == $past(host_wdata[IB_AW-1:0])));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && host_wr && host_addr == OFS_CMD)
        |=> (cmd_addr_q == $past(cmd_addr_q) && cmd_dir_q == $past(cmd_dir_q)));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (irq_en && irq_flag));
endmodule

// File: tb/test_indirect_byte_bridge.sv
module test_indirect_byte_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int SYNC       = 2;
    localparam logic [31:0] ID = 32'h1B0D_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq;
    logic        ib_req;
    logic        ib_we;
    logic [7:0]  ib_addr;
    logic [7:0]  ib_wdata;
    logic [7:0]  ib_rdata;
    logic        ib_irq = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Narrow-bus target model: returns address XOR 0x5A.
    assign ib_rdata = ib_addr ^ 8'h5A;

    indirect_byte_bridge #(
        .XFER_CYCLES (LAT),
        .SYNC_STAGES (SYNC),
        .IB_AW       (8),
        .ID_VALUE    (ID)
    ) i_indirect_byte_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_irq   (host_irq),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .ib_addr    (ib_addr),
        .ib_wdata   (ib_wdata),
        .ib_rdata   (ib_rdata),
        .ib_irq     (ib_irq)
    );

    // {is_write, addr, data, expected}
    localparam int NV = 13;
    localparam logic [69:0] VECS [NV] = '{
        {1'b0, 5'h00, 32'h0,         ID},            // R2 id
        {1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0},         // R2 write ignored
        {1'b0, 5'h00, 32'h0,         ID},            // R2
        {1'b1, 5'h0C, 32'hDEAD_BEEF, 32'h0},         // R12
        {1'b0, 5'h0C, 32'h0,         32'hDEAD_BEEF}, // R12
        {1'b1, 5'h10, 32'hFFFF_FFFF, 32'h0},         // R10 only bit 1
        {1'b0, 5'h10, 32'h0,         32'h0000_0002}, // R10
        {1'b1, 5'h10, 32'h0,         32'h0},         // R10
        {1'b0, 5'h10, 32'h0,         32'h0},         // R10
        {1'b1, 5'h04, 32'h80F1_00A5, 32'h0},         // R3 busy not writable
        {1'b0, 5'h04, 32'h0,         32'h00F1_00A5}, // R3
        {1'b1, 5'h04, 32'h7E0F_FF3C, 32'h0},         // R3 unused bits
        {1'b0, 5'h04, 32'h0,         32'h000F_003C}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(5'h04, rd); chk("R1 cmd", rd, 32'h0);
        hread(5'h08, rd); chk("R1 ldata", rd, 32'h0);
        hread(5'h14, rd); chk("R1 flag", rd, 32'h0);
        hread(5'h10, rd); chk("R1 enable", rd, 32'h0);
        chk("R1 ib_req", {31'b0, ib_req}, 32'h0);
        chk("R1 host_irq", {31'b0, host_irq}, 32'h0);

        // Register table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][69]) begin
                hwrite(VECS[i][68:64], VECS[i][63:32]);
            end else begin
                hread(VECS[i][68:64], rd);
                chk("R2/R3/R10/R12 table", rd, VECS[i][31:0]);
            end
        end

        // R4 write transaction and R6 busy length
        hwrite(5'h04, 32'h0001_0033);
        hwrite(5'h08, 32'h0000_00C7);
        chk("R4 ib_req", {31'b0, ib_req}, 32'h1);
        chk("R4 ib_we", {31'b0, ib_we}, 32'h1);
        chk("R4 ib_addr", {24'b0, ib_addr}, 32'h33);
        chk("R4 ib_wdata", {24'b0, ib_wdata}, 32'hC7);
        n = 0;
        hread(5'h04, rd);
        while (rd[31] && n < 100) begin
            n++;
            @(negedge clk);
            hread(5'h04, rd);
        end
        chk("R6 busy cycles", n, LAT);
        chk("R6 ib_req low", {31'b0, ib_req}, 32'h0);
        hread(5'h08, rd); chk("R4 ldata kept", rd, 32'hC7);

        // R5 read launch, R8 writes while busy, R7 read result
        hwrite(5'h04, 32'h0101_0021);
        chk("R5 ib_req", {31'b0, ib_req}, 32'h1);
        chk("R5 ib_we", {31'b0, ib_we}, 32'h0);
        chk("R5 ib_addr", {24'b0, ib_addr}, 32'h21);
        hwrite(5'h04, 32'h0001_0044);
        hwrite(5'h08, 32'h0000_0055);
        chk("R8 ib_addr stable", {24'b0, ib_addr}, 32'h21);
        n = 0;
        hread(5'h04, rd);
        while (rd[31] && n < 100) begin
            n++;
            @(negedge clk);
            hread(5'h04, rd);
        end
        chk("R8 cmd unchanged", rd, 32'h0101_0021);
        hread(5'h08, rd); chk("R7 read byte", rd, 32'h0000_007B);
        @(negedge clk);
        chk("R8 no relaunch", {31'b0, ib_req}, 32'h0);

        // R11 data write with read direction stored
        hwrite(5'h08, 32'h0000_0099);
        chk("R11 no launch", {31'b0, ib_req}, 32'h0);
        hread(5'h08, rd); chk("R11 ldata stored", rd, 32'h99);

        // R9 / R10 interrupt path
        hwrite(5'h10, 32'h2);
        ib_irq = 1'b1;
        n = 0;
        hread(5'h14, rd);
        while (!rd[1] && n < 50) begin
            @(negedge clk);
            ib_irq = 1'b0;
            n++;
            hread(5'h14, rd);
        end
        chk("R9 flag delay", n, SYNC + 1);
        chk("R10 irq on", {31'b0, host_irq}, 32'h1);
        hwrite(5'h14, 32'h0);
        hread(5'h14, rd); chk("R9 write 0 keeps", rd, 32'h2);
        hwrite(5'h14, 32'h2);
        hread(5'h14, rd); chk("R9 w1c clears", rd, 32'h0);
        chk("R10 irq off after clear", {31'b0, host_irq}, 32'h0);
        hwrite(5'h10, 32'h0);
        ib_irq = 1'b1;
        @(negedge clk);
        ib_irq = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        hread(5'h14, rd); chk("R9 flag set again", rd, 32'h2);
        chk("R10 gated off", {31'b0, host_irq}, 32'h0);

        finish_run();
    end
endmodule